// File: doc/BRIEF.md
# Linked Descriptor Queue Manager

This block keeps one DMA queue whose entries live as a linked chain of 20-byte descriptors in an external word-wide descriptor memory. The queue state inside the block is a head pointer, a tail pointer and a fixed terminator pointer, so the queue is empty when the head equals the terminator. A single command port lets a controller remove the packet at the head, append a packet in front of the terminator, give a descriptor back to hardware, reset a receive descriptor to its default contents, or count the descriptors in the queue.

A packet may span several descriptors. The first descriptor holds a pointer to the last descriptor of its packet, so a dequeue skips the whole packet in one operation by following that pointer and then the last descriptor's next pointer. A dequeue can be made conditional on the 2-bit ownership code in the head descriptor's status: it can remove the head only when the code equals a requested value, or only when it differs. Each command runs as a short sequence of single-word memory accesses. The memory has a one-cycle read latency, and the block reports completion with a one-cycle `done` pulse together with its result.

Top module: `dq_chain_mgr`

## Requirements
- R1: After reset the head equals the terminator pointer `TERM_PTR`, `q_empty` is 1 and `busy` is 0. `q_empty` is 1 exactly when `head_ptr` equals `TERM_PTR`.
- R2: Op 0 (unconditional dequeue) on a non-empty queue returns the old head in `res_ptr` with `res_valid`=1. The new head is the word-4 (next) pointer of the descriptor named by the head's word-2 (last) pointer, so a multi-descriptor packet leaves in one operation.
- R3: Op 1 removes the head packet only when head status bits [1:0] equal `cmd_own`. Otherwise it completes with `res_valid`=0 and the head unchanged.
- R4: Op 2 removes the head packet only when head status bits [1:0] differ from `cmd_own`. Otherwise it completes with `res_valid`=0 and the head unchanged.
- R5: Any dequeue op (0, 1 or 2) on an empty queue completes with `res_valid`=0 and leaves the queue empty.
- R6: Op 3 (append `cmd_desc`) writes `TERM_PTR` into the next word of the packet's last descriptor. If the queue was empty, the head becomes `cmd_desc`. Otherwise the previous tail packet's last descriptor gets `cmd_desc` as its next word.
- R7: Op 4 (re-arm `cmd_desc`) sets status bits [1:0] to 1 (hardware owned) and keeps every other bit of word 0 (status and control) unchanged.
- R8: Op 5 (receive reset of `cmd_desc`) writes word 0 = 0x0000_0001, word 1 = `BLOCK_BYTES` << 16 (total length 320 by default, data size 0) and word 2 = `cmd_desc`. Words 3 and 4 stay untouched.
- R9: Op 6 (count) returns in `res_len` the number of descriptors met along next pointers from the head to the terminator, with `res_err`=0. The count saturates at 0xFFFF.
- R10: If a count has taken `MAX_STEPS` steps without reaching the terminator, it stops with `res_err`=1 and `res_len`=`MAX_STEPS`.
- R11: A command is accepted only while `busy`=0. `busy` is 1 from the cycle after a multi-access command is accepted until completion. `done` is a one-cycle pulse seen with `busy`=0, and the memory is not accessed while the block is idle.
- R12: A descriptor at byte pointer p fills memory words p/4 to p/4+4 in this order: {control, status}, {total length, data size}, last pointer, data pointer, next pointer. The ownership code is status bits [1:0]: 0 means software, 1 means hardware, 2 is a third state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 3 | 0 dequeue, 1 dequeue-if-equal, 2 dequeue-if-differ, 3 append, 4 re-arm, 5 receive reset, 6 count |
| cmd_own | input | 2 | Ownership code compared by ops 1 and 2 |
| cmd_desc | input | 32 | Descriptor byte pointer for ops 3, 4 and 5 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | A packet was unlinked by the completed dequeue |
| res_ptr | output | 32 | First descriptor of the unlinked packet |
| res_len | output | 16 | Descriptor count from op 6 |
| res_err | output | 1 | Count hit its step limit |
| head_ptr | output | 32 | Current head pointer |
| q_empty | output | 1 | Head equals terminator |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
The assertions assume that the descriptor memory returns read data exactly one cycle after a read and that no other agent writes the words the block is walking during a command. They also assume that every last pointer in the queue names a descriptor of the same packet. The stimulus builds all descriptor chains only while the block is idle. It gives every appended packet a consistent last pointer, and it changes links by hand only in the deliberate cyclic chain that exercises the step limit. Commands are raised only while `busy` is low.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int WORD_W = 32;
  localparam int PTR_W  = 32;
  localparam int LEN_W  = 16;

  localparam logic [1:0] OWN_SW = 2'd0;
  localparam logic [1:0] OWN_HW = 2'd1;
  localparam logic [1:0] OWN_SE = 2'd2;

  // word offsets inside a descriptor
  localparam int OFF_STAT = 0;
  localparam int OFF_SIZE = 1;
  localparam int OFF_LAST = 2;
  localparam int OFF_DATA = 3;
  localparam int OFF_NEXT = 4;

  typedef enum logic [2:0] {
    OP_DEQ_ANY = 3'd0,
    OP_DEQ_EQ  = 3'd1,
    OP_DEQ_NE  = 3'd2,
    OP_APPEND  = 3'd3,
    OP_REARM   = 3'd4,
    OP_RX_INIT = 3'd5,
    OP_COUNT   = 3'd6
  } dq_op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_DQ_STAT, S_DQ_CHK, S_DQ_LAST, S_DQ_NEXT, S_DQ_UPD,
    S_AP_LAST, S_AP_TERM, S_AP_LINK, S_AR_RD, S_AR_WR,
    S_RX_W0, S_RX_W1, S_RX_W2, S_CN_TEST, S_CN_WAIT
  } dq_state_e;

  function automatic logic is_deq(input dq_op_e op);
    return (op == OP_DEQ_ANY) || (op == OP_DEQ_EQ) || (op == OP_DEQ_NE);
  endfunction
endpackage

// File: rtl/dq_own_gate.sv
module dq_own_gate
  import dq_pkg::*;
(
  input  dq_op_e     mode,
  input  logic [1:0] have,
  input  logic [1:0] want,
  output logic       take
);
  always_comb begin
    case (mode)
      OP_DEQ_EQ: take = (have == want);
      OP_DEQ_NE: take = (have != want);
      default:   take = 1'b1;
    endcase
  end
endmodule

// File: rtl/dq_len_walker.sv
module dq_len_walker
  import dq_pkg::*;
#(
  parameter int MAX_STEPS = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [LEN_W-1:0] len,
  output logic             at_limit
);
  localparam int SW = $clog2(MAX_STEPS + 1);
  localparam logic [SW-1:0] LIMIT = SW'(MAX_STEPS);

  logic [SW-1:0] steps;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len   <= '0;
      steps <= '0;
    end else if (step) begin
      if (len != {LEN_W{1'b1}}) len <= len + 1'b1;
      if (steps != LIMIT) steps <= steps + 1'b1;
    end
  end

  assign at_limit = (steps == LIMIT);

  AST_LEN_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && len == {LEN_W{1'b1}}) |=> (len == {LEN_W{1'b1}})); // R9
endmodule

// File: rtl/dq_chain_mgr.sv
module dq_chain_mgr
  import dq_pkg::*;
#(
  parameter int          MEM_AW      = 10,
  parameter logic [31:0] TERM_PTR    = 32'h0000_0000,
  parameter int          BLOCK_BYTES = 320,
  parameter int          MAX_STEPS   = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_own,
  input  logic [31:0]       cmd_desc,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic [31:0]       res_ptr,
  output logic [15:0]       res_len,
  output logic              res_err,
  output logic [31:0]       head_ptr,
  output logic              q_empty,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam logic [LEN_W-1:0] BLK_LEN = LEN_W'(BLOCK_BYTES);

  function automatic logic [MEM_AW-1:0] wa(input logic [PTR_W-1:0] p, input int off);
    return p[MEM_AW+1:2] + MEM_AW'(off);
  endfunction

  dq_state_e         st;
  dq_op_e            op_in, op_q;
  logic [1:0]        own_q;
  logic [PTR_W-1:0]  desc_q, head_q, tail_q, walk_q, newtail_q;
  logic              done_q, res_valid_q, res_err_q;
  logic [PTR_W-1:0]  res_ptr_q;
  logic [LEN_W-1:0]  res_len_q;
  logic              take, walk_clr, walk_step, at_limit;
  logic [LEN_W-1:0]  walk_len;
  logic              accept, op_ok;

  assign op_in  = dq_op_e'(cmd_op);
  assign op_ok  = (cmd_op <= 3'd6);
  assign accept = (st == S_IDLE) && cmd_valid && op_ok;

  dq_own_gate u_gate (
    .mode (op_q),
    .have (mem_rdata[1:0]),
    .want (own_q),
    .take (take)
  );

  assign walk_clr  = accept && (op_in == OP_COUNT);
  assign walk_step = (st == S_CN_TEST) && (walk_q != TERM_PTR) && !at_limit;

  dq_len_walker #(.MAX_STEPS(MAX_STEPS)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .clr      (walk_clr),
    .step     (walk_step),
    .len      (walk_len),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      op_q        <= OP_DEQ_ANY;
      own_q       <= OWN_SW;
      desc_q      <= '0;
      head_q      <= TERM_PTR;
      tail_q      <= TERM_PTR;
      walk_q      <= TERM_PTR;
      newtail_q   <= TERM_PTR;
      done_q      <= 1'b0;
      res_valid_q <= 1'b0;
      res_err_q   <= 1'b0;
      res_ptr_q   <= '0;
      res_len_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            res_valid_q <= 1'b0;
            res_err_q   <= 1'b0;
            op_q        <= op_in;
            own_q       <= cmd_own;
            desc_q      <= cmd_desc;
            if (is_deq(op_in)) begin
              if (head_q == TERM_PTR) begin
                done_q    <= 1'b1;
                res_ptr_q <= '0;
              end else begin
                st <= (op_in == OP_DEQ_ANY) ? S_DQ_LAST : S_DQ_STAT;
              end
            end else begin
              case (op_in)
                OP_APPEND:  st <= S_AP_LAST;
                OP_REARM:   st <= S_AR_RD;
                OP_RX_INIT: st <= S_RX_W0;
                default: begin
                  walk_q <= head_q;
                  st     <= S_CN_TEST;
                end
              endcase
            end
          end
        end
        S_DQ_STAT: st <= S_DQ_CHK;
        S_DQ_CHK: begin
          if (take) st <= S_DQ_LAST;
          else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_DQ_LAST: st <= S_DQ_NEXT;
        S_DQ_NEXT: st <= S_DQ_UPD;
        S_DQ_UPD: begin
          head_q      <= mem_rdata;
          res_ptr_q   <= head_q;
          res_valid_q <= 1'b1;
          done_q      <= 1'b1;
          st          <= S_IDLE;
        end
        S_AP_LAST: st <= S_AP_TERM;
        S_AP_TERM: begin
          newtail_q <= mem_rdata;
          st        <= S_AP_LINK;
        end
        S_AP_LINK: begin
          if (head_q == TERM_PTR) head_q <= desc_q;
          tail_q <= newtail_q;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_AR_RD: st <= S_AR_WR;
        S_AR_WR: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_RX_W0: st <= S_RX_W1;
        S_RX_W1: st <= S_RX_W2;
        S_RX_W2: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_CN_TEST: begin
          if (walk_q == TERM_PTR) begin
            res_len_q <= walk_len;
            done_q    <= 1'b1;
            st        <= S_IDLE;
          end else if (at_limit) begin
            res_len_q <= walk_len;
            res_err_q <= 1'b1;
            done_q    <= 1'b1;
            st        <= S_IDLE;
          end else begin
            st <= S_CN_WAIT;
          end
        end
        S_CN_WAIT: begin
          walk_q <= mem_rdata;
          st     <= S_CN_TEST;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_DQ_STAT: begin mem_en = 1'b1; mem_addr = wa(head_q, OFF_STAT); end
      S_DQ_LAST: begin mem_en = 1'b1; mem_addr = wa(head_q, OFF_LAST); end
      S_DQ_NEXT: begin mem_en = 1'b1; mem_addr = wa(mem_rdata, OFF_NEXT); end
      S_AP_LAST: begin mem_en = 1'b1; mem_addr = wa(desc_q, OFF_LAST); end
      S_AP_TERM: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = wa(mem_rdata, OFF_NEXT); mem_wdata = TERM_PTR;
      end
      S_AP_LINK: begin
        if (head_q != TERM_PTR) begin
          mem_en = 1'b1; mem_we = 1'b1;
          mem_addr = wa(tail_q, OFF_NEXT); mem_wdata = desc_q;
        end
      end
      S_AR_RD: begin mem_en = 1'b1; mem_addr = wa(desc_q, OFF_STAT); end
      S_AR_WR: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = wa(desc_q, OFF_STAT); mem_wdata = {mem_rdata[31:2], OWN_HW};
      end
      S_RX_W0: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = wa(desc_q, OFF_STAT); mem_wdata = {30'd0, OWN_HW};
      end
      S_RX_W1: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = wa(desc_q, OFF_SIZE); mem_wdata = {BLK_LEN, 16'd0};
      end
      S_RX_W2: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = wa(desc_q, OFF_LAST); mem_wdata = desc_q;
      end
      S_CN_TEST: begin
        if (walk_step) begin mem_en = 1'b1; mem_addr = wa(walk_q, OFF_NEXT); end
      end
      default: ;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign res_valid = res_valid_q;
  assign res_ptr   = res_ptr_q;
  assign res_len   = res_len_q;
  assign res_err   = res_err_q;
  assign head_ptr  = head_q;
  assign q_empty   = (head_q == TERM_PTR);

  AST_EMPTY_DEQ: assert property (@(posedge clk) disable iff (rst)
    (accept && is_deq(op_in) && q_empty) |=> (done && !res_valid && q_empty)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en); // R11
  AST_REARM_KEEP: assert property (@(posedge clk) disable iff (rst)
    (st == S_AR_WR) |-> (mem_we && mem_wdata[31:2] == mem_rdata[31:2] && mem_wdata[1:0] == OWN_HW)); // R7
endmodule

// File: tb/dq_chain_mgr_tb.sv
module dq_chain_mgr_tb;
  localparam int MEM_AW = 8;
  localparam int MAXS   = 8;
  localparam logic [31:0] TERM = 32'h0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_own = '0;
  logic [31:0] cmd_desc = '0;
  logic busy, done, res_valid, res_err, q_empty, mem_en, mem_we;
  logic [31:0] res_ptr, head_ptr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [15:0] res_len;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0] mem [0:255];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dq_chain_mgr #(.MEM_AW(MEM_AW), .TERM_PTR(TERM), .BLOCK_BYTES(320), .MAX_STEPS(MAXS)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_own(cmd_own),
    .cmd_desc(cmd_desc), .busy(busy), .done(done), .res_valid(res_valid), .res_ptr(res_ptr),
    .res_len(res_len), .res_err(res_err), .head_ptr(head_ptr), .q_empty(q_empty),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct {
    string       tag;
    logic        v;
    logic [31:0] p;
    logic        cnt;
    logic [15:0] len;
    logic        err;
  } exp_t;

  exp_t sbq[$];
  exp_t e_mon;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t ex(input string t, input logic v, input logic [31:0] p,
                              input logic c, input logic [15:0] l, input logic er);
    exp_t e;
    e.tag = t; e.v = v; e.p = p; e.cnt = c; e.len = l; e.err = er;
    return e;
  endfunction

  function automatic logic [31:0] dp(input int i);
    return 32'(20 * i);
  endfunction

  function automatic int wa(input int i, input int off);
    return 5 * i + off;
  endfunction

  // monitor: pop expected result at each completion
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        chk("R11 unexpected done", 32'd1, 32'd0);
      end else begin
        e_mon = sbq.pop_front();
        chk({e_mon.tag, " res_valid"}, 32'(res_valid), 32'(e_mon.v));
        if (e_mon.v) chk({e_mon.tag, " res_ptr"}, res_ptr, e_mon.p);
        if (e_mon.cnt) begin
          chk({e_mon.tag, " res_len"}, 32'(res_len), 32'(e_mon.len));
          chk({e_mon.tag, " res_err"}, 32'(res_err), 32'(e_mon.err));
        end
        chk({e_mon.tag, " R11 busy low at done"}, 32'(busy), 32'd0);
      end
    end
  end

  task automatic run(input logic [2:0] op, input logic [1:0] own, input logic [31:0] d,
                     input exp_t e, input bit multi);
    sbq.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_own = own; cmd_desc = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (multi) chk({e.tag, " R11 busy"}, 32'(busy), 32'd1);
    while (!done) @(negedge clk);
  endtask

  task automatic setd(input int i, input logic [15:0] stat, input logic [15:0] ctrl,
                      input logic [31:0] last, input logic [31:0] nxt);
    mem[wa(i, 0)] = {ctrl, stat};
    mem[wa(i, 1)] = {16'd320, 16'd100};
    mem[wa(i, 2)] = last;
    mem[wa(i, 3)] = 32'hDA7A_0000 + 32'(i);
    mem[wa(i, 4)] = nxt;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset q_empty", 32'(q_empty), 32'd1);
    chk("R1 reset head", head_ptr, TERM);
    chk("R1 reset busy", 32'(busy), 32'd0);

    run(3'd6, 2'd0, 32'd0, ex("R9 count empty", 1'b0, 0, 1'b1, 16'd0, 1'b0), 1'b1);
    run(3'd0, 2'd0, 32'd0, ex("R5 deq any empty", 1'b0, 0, 1'b0, 0, 1'b0), 1'b0);
    run(3'd1, 2'd0, 32'd0, ex("R5 deq eq empty", 1'b0, 0, 1'b0, 0, 1'b0), 1'b0);
    chk("R5 still empty", 32'(q_empty), 32'd1);

    // P1 = d1,d2 (software owned), P2 = d3 (hardware), P3 = d4 (third state)
    setd(1, 16'h0000, 16'h0200, dp(2), dp(2));
    setd(2, 16'h0000, 16'h0100, dp(2), 32'hFFFF_FFF0);
    setd(3, 16'h0001, 16'h0300, dp(3), 32'hFFFF_FFF0);
    setd(4, 16'hABC2, 16'h0301, dp(4), 32'hFFFF_FFF0);

    run(3'd3, 2'd0, dp(1), ex("R6 append P1", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R6 head after first append", head_ptr, dp(1));
    chk("R6 P1 last next = term", mem[wa(2, 4)], TERM);
    run(3'd3, 2'd0, dp(3), ex("R6 append P2", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R6 tail linked to P2", mem[wa(2, 4)], dp(3));
    chk("R6 P2 next = term", mem[wa(3, 4)], TERM);
    chk("R6 head kept", head_ptr, dp(1));
    run(3'd3, 2'd0, dp(4), ex("R6 append P3", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R6 P2 linked to P3", mem[wa(3, 4)], dp(4));

    run(3'd6, 2'd0, 32'd0, ex("R9 count four", 1'b0, 0, 1'b1, 16'd4, 1'b0), 1'b1);

    run(3'd1, 2'd1, 32'd0, ex("R3 eq mismatch", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R3 head unchanged", head_ptr, dp(1));
    run(3'd2, 2'd0, 32'd0, ex("R4 ne mismatch", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R4 head unchanged", head_ptr, dp(1));
    run(3'd1, 2'd0, 32'd0, ex("R3 eq match", 1'b1, dp(1), 1'b0, 0, 1'b0), 1'b1);
    chk("R2 multi-descriptor skip", head_ptr, dp(3));
    run(3'd2, 2'd0, 32'd0, ex("R4 ne match", 1'b1, dp(3), 1'b0, 0, 1'b0), 1'b1);
    chk("R4 head advanced", head_ptr, dp(4));
    run(3'd2, 2'd2, 32'd0, ex("R4 ne equal code", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);

    run(3'd4, 2'd0, dp(4), ex("R7 rearm", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R7 R12 rearm word0", mem[wa(4, 0)], 32'h0301_ABC1);
    run(3'd1, 2'd1, 32'd0, ex("R3 eq after rearm", 1'b1, dp(4), 1'b0, 0, 1'b0), 1'b1);
    chk("R1 empty after last", 32'(q_empty), 32'd1);
    chk("R1 head = term", head_ptr, TERM);

    // re-append P1 after emptying, then drain with op 0
    setd(1, 16'h0002, 16'h0200, dp(2), dp(2));
    run(3'd3, 2'd0, dp(1), ex("R6 append after drain", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R6 head after refill", head_ptr, dp(1));
    run(3'd0, 2'd0, 32'd0, ex("R2 deq any", 1'b1, dp(1), 1'b0, 0, 1'b0), 1'b1);
    chk("R2 empty after any", 32'(q_empty), 32'd1);

    mem[wa(5, 0)] = 32'hFFFF_FFFE;
    mem[wa(5, 1)] = 32'hFFFF_FFFF;
    mem[wa(5, 2)] = 32'h1234_0000;
    mem[wa(5, 3)] = 32'hDA7A_5555;
    mem[wa(5, 4)] = 32'h1234_5678;
    run(3'd5, 2'd0, dp(5), ex("R8 rx reset", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    chk("R8 R12 word0", mem[wa(5, 0)], 32'h0000_0001);
    chk("R8 R12 word1", mem[wa(5, 1)], 32'h0140_0000);
    chk("R8 word2 self", mem[wa(5, 2)], dp(5));
    chk("R8 word3 kept", mem[wa(5, 3)], 32'hDA7A_5555);
    chk("R8 word4 kept", mem[wa(5, 4)], 32'h1234_5678);

    // cyclic chain for the step limit
    setd(6, 16'h0001, 16'h0000, dp(6), dp(7));
    setd(7, 16'h0001, 16'h0000, dp(7), dp(6));
    run(3'd3, 2'd0, dp(6), ex("R6 append loop head", 1'b0, 0, 1'b0, 0, 1'b0), 1'b1);
    mem[wa(6, 4)] = dp(7);
    run(3'd6, 2'd0, 32'd0, ex("R10 count limit", 1'b0, 0, 1'b1, 16'(MAXS), 1'b1), 1'b1);

    repeat (3) @(negedge clk);
    chk("R11 all results seen", 32'(sbq.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule